// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block turns the system clock into the bit timing for an I2C master. A first-stage prescaler divides the system clock by a programmable amount to form an internal-clock enable. A second-stage phase counter counts those enables to build one SCL period. The period has a fixed base of 20 internal-clock cycles. It adds 8 cycles for each unit of a 6-bit step setting, plus a compensation count for rise time, fall time and internal delay. That compensation is already rounded up to an integer by whoever supplies it.

The byte engine raises `run` while a transfer is active. While `run` is high the block produces the SCL level and one-cycle strobes that mark the start of each low phase and each high phase. Software writes one packed configuration word, and the compensation input is captured at the same moment. A new setting is held back until the SCL period in progress has finished, so SCL never shows a shortened pulse. While the engine is idle, every counter is held at zero and SCL stays released high.

Top module: `scl_rate_gen`

## Requirements
- R1: The configuration word places the prescale code in bits [2:0] and the 6-bit step setting in bits [8:3].
- R2: While running, `ick_en` is high for one system clock in every (prescale code + 1) clocks.
- R3: One SCL period spans exactly 20 + 8 × step + comp internal-clock enables, from 20 (all zero) up to 587 (step 63, comp 63).
- R4: The low phase of a period lasts ceil(P/2) enables and the high phase lasts the remaining P − ceil(P/2), for a period of P enables.
- R5: A configuration write made during a period leaves that period's length and prescale rate unchanged. The new values apply from the next period boundary on.
- R6: `comp_cnt` is captured only when `cfg_we` is high. Changing it at any other time has no effect on SCL timing.
- R7: One clock after `run` is low, SCL is released high (`scl_o` = 1) and no `ick_en` or strobe is produced. One clock after `run` rises, a fresh period begins with its low phase.
- R8: `low_stb` is high for one clock, in the first clock in which `scl_o` is low for a period. `high_stb` is high for one clock, in the first clock in which `scl_o` is high after a low phase. The two are never high together.
- R9: After a synchronous reset, `scl_o` is 1 and `ick_en`, `low_stb` and `high_stb` are 0. The stored configuration is all zero, which gives a 20-enable period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High while the byte engine needs SCL timing |
| cfg_we | input | 1 | Write strobe for the configuration word and compensation |
| cfg_word | input | 9 | Packed configuration: [2:0] prescale code, [8:3] step setting |
| comp_cnt | input | 6 | Rise/fall compensation in internal-clock cycles, captured on `cfg_we` |
| ick_en | output | 1 | Internal-clock enable, one system clock wide |
| scl_o | output | 1 | SCL level: 0 drives low, 1 releases high |
| low_stb | output | 1 | Marks the first clock of each SCL low phase |
| high_stb | output | 1 | Marks the first clock of each SCL high phase |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the middle of a running period and changes both the prescale code and the period length. The deferred values must then take over exactly at the wrap, and the enable spacing must not glitch. The stimulus lines up on a `low_stb`, waits a fixed number of clocks, and issues the write in a parallel branch while a measuring task counts the enables of that same period. It then checks the next period and the new enable spacing. A separate step changes `comp_cnt` without a write, and the bench confirms that the period stays the same until a real write captures the new value.

// File: rtl/scl_div_pkg.sv
// Package: shared widths, configuration record and period arithmetic for
// the SCL rate divider. Assumes the base and step multiplier are fixed at
// build time; only the field widths are meant to be changed.
package scl_div_pkg;

    localparam int DIV_W      = 3;   // prescale code width
    localparam int STEP_W     = 6;   // step setting width
    localparam int COMP_W     = 6;   // compensation count width
    localparam int BASE_TICKS = 20;  // fixed part of every period
    localparam int STEP_SHIFT = 3;   // each step adds 2**STEP_SHIFT ticks

    localparam int CFG_W   = DIV_W + STEP_W;
    localparam int PER_MAX = BASE_TICKS
                           + (((1 << STEP_W) - 1) << STEP_SHIFT)
                           + ((1 << COMP_W) - 1);
    localparam int PER_W   = $clog2(PER_MAX + 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [DIV_W-1:0]  div;
        logic [COMP_W-1:0] comp;
    } rate_cfg_t;

    // Full SCL period in internal-clock ticks for a configuration.
    function automatic logic [PER_W-1:0] period_of(rate_cfg_t c);
        return PER_W'(BASE_TICKS)
             + (PER_W'(c.step) << STEP_SHIFT)
             + PER_W'(c.comp);
    endfunction

    // Low-phase length: half the period, rounded up.
    function automatic logic [PER_W-1:0] low_of(logic [PER_W-1:0] per);
        logic [PER_W:0] sum;
        sum = {1'b0, per} + {{PER_W{1'b0}}, 1'b1};
        return sum[PER_W:1];
    endfunction

endpackage

// File: rtl/scl_cfg_stage.sv
// Configuration staging. Captures the packed word and the compensation
// input on a write. It hands an active copy to the counters only when
// `load` is high, which the top drives at period boundaries and while idle.
// Assumes the word layout {step, div} with div in the low bits.
module scl_cfg_stage
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_word,
    input  logic [COMP_W-1:0] comp_in,
    input  logic              load,
    output rate_cfg_t         act_cfg
);

    rate_cfg_t pend_q;
    rate_cfg_t pend_nxt;
    rate_cfg_t act_q;

    // Select the freshly written value or keep the held one.
    always_comb begin
        if (wr_en) begin
            pend_nxt.div  = wr_word[DIV_W-1:0];
            pend_nxt.step = wr_word[CFG_W-1:DIV_W];
            pend_nxt.comp = comp_in;
        end else begin
            pend_nxt = pend_q;
        end
    end

    // Hold the last written configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    // Promote the pending configuration at a boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '0;
        else if (load) act_q <= pend_nxt;
    end

    assign act_cfg = act_q;

endmodule

// File: rtl/scl_prescaler.sv
// First-stage divider. Emits a one-clock enable every (div_code + 1)
// system clocks while `en` is high. The count is cleared while idle so
// that the first enable after start comes a full interval later.
// Assumes div_code changes only in a cycle in which `tick` is high.
module scl_prescaler
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_top;

    assign at_top = (cnt_q == div_code);
    assign tick   = en && at_top;

    // Count system clocks within one internal-clock interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (at_top)   cnt_q <= '0;
        else               cnt_q <= cnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/scl_phase_ctr.sv
// Second-stage counter. Walks through one SCL period in internal-clock
// ticks, drives the SCL level and registers the phase-start strobes so
// that they line up with the level change. Assumes period >= 2 and that
// period and low_len change only when `wrap` is high or while idle.
module scl_phase_ctr
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run_nxt,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] low_len,
    output logic [PER_W-1:0] pos,
    output logic             wrap,
    output logic             scl_o,
    output logic             low_stb,
    output logic             high_stb
);

    logic [PER_W-1:0] pos_q;
    logic             last_pos;
    logic             last_low;
    logic             low_q;
    logic             high_q;

    assign last_pos = (pos_q == period - PER_W'(1));
    assign last_low = (pos_q == low_len - PER_W'(1));
    assign wrap     = tick && last_pos;

    // Advance the position inside the period on each internal tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) pos_q <= '0;
        else if (wrap)     pos_q <= '0;
        else if (tick)     pos_q <= pos_q + PER_W'(1);
    end

    // Flag the first clock of each low and high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= 1'b0;
            high_q <= 1'b0;
        end else begin
            low_q  <= run_nxt && (!en || wrap);
            high_q <= run_nxt && en && tick && last_low;
        end
    end

    assign pos      = pos_q;
    assign scl_o    = !(en && (pos_q < low_len));
    assign low_stb  = low_q;
    assign high_stb = high_q;

endmodule

// File: rtl/scl_rate_gen.sv
// Top of the SCL rate divider. Registers the engine's run request, stages
// the configuration and chains the prescaler into the phase counter.
// Assumes the byte engine samples scl_o and the strobes on the system clock.
module scl_rate_gen
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cfg_we,
    input  logic [8:0]        cfg_word,
    input  logic [5:0]        comp_cnt,
    output logic              ick_en,
    output logic              scl_o,
    output logic              low_stb,
    output logic              high_stb
);

    logic             en_q;
    logic             wrap_w;
    logic             load_w;
    rate_cfg_t        act_cfg;
    logic [PER_W-1:0] period_w;
    logic [PER_W-1:0] low_w;
    logic [PER_W-1:0] pos_q;

    // Register the run request so every stage sees one start cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= run;
    end

    assign load_w   = !en_q || wrap_w;
    assign period_w = period_of(act_cfg);
    assign low_w    = low_of(period_w);

    scl_cfg_stage i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_word (CFG_W'(cfg_word)),
        .comp_in (COMP_W'(comp_cnt)),
        .load    (load_w),
        .act_cfg (act_cfg)
    );

    scl_prescaler i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .div_code (act_cfg.div),
        .tick     (ick_en)
    );

    scl_phase_ctr i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .run_nxt  (run),
        .tick     (ick_en),
        .period   (period_w),
        .low_len  (low_w),
        .pos      (pos_q),
        .wrap     (wrap_w),
        .scl_o    (scl_o),
        .low_stb  (low_stb),
        .high_stb (high_stb)
    );

endmodule

// File: rtl/scl_rate_chk.sv
// Checker for the SCL rate divider, bound to the top. Observes ports and
// the active configuration and phase position.
module scl_rate_chk
    import scl_div_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             ick_en,
    input logic             scl_o,
    input logic             low_stb,
    input logic             high_stb,
    input rate_cfg_t        act_cfg,
    input logic [PER_W-1:0] pos,
    input logic [PER_W-1:0] period
);

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (scl_o && !ick_en && !low_stb && !high_stb));

    // R8
    low_strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_stb |-> !scl_o);

    // R8
    high_strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_stb |-> scl_o);

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_stb && high_stb));

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ick_en) && act_cfg.div != '0) |-> !ick_en);

    // R3
    pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos < period);

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != '0) |-> $stable(act_cfg));

endmodule

bind scl_rate_gen scl_rate_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ick_en   (ick_en),
    .scl_o    (scl_o),
    .low_stb  (low_stb),
    .high_stb (high_stb),
    .act_cfg  (act_cfg),
    .pos      (pos_q),
    .period   (period_w)
);

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_word = '0;
    logic [5:0] comp_cnt = '0;
    logic       ick_en, scl_o, low_stb, high_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit model_on = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    scl_rate_gen i_scl_rate_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
        .cfg_word(cfg_word), .comp_cnt(comp_cnt), .ick_en(ick_en),
        .scl_o(scl_o), .low_stb(low_stb), .high_stb(high_stb)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_en, m_pc, m_pos, m_lo, m_hi;
    int p_div, p_step, p_comp, a_div, a_step, a_comp;

    function automatic int m_per();
        return 20 + 8 * a_step + a_comp;
    endfunction

    always @(posedge clk) begin
        int n_div, n_step, n_comp, per, low, tk, wr;
        if (!rst_n) begin
            m_en = 0; m_pc = 0; m_pos = 0; m_lo = 0; m_hi = 0;
            p_div = 0; p_step = 0; p_comp = 0;
            a_div = 0; a_step = 0; a_comp = 0;
            model_on = 1'b1;
        end else begin
            if (cfg_we) begin
                n_div = cfg_word % 8; n_step = cfg_word / 8; n_comp = comp_cnt;
            end else begin
                n_div = p_div; n_step = p_step; n_comp = p_comp;
            end
            per = m_per();
            low = (per + 1) / 2;
            tk  = (m_en != 0 && m_pc == a_div) ? 1 : 0;
            wr  = (tk != 0 && m_pos == per - 1) ? 1 : 0;
            m_lo = (run && (m_en == 0 || wr != 0)) ? 1 : 0;
            m_hi = (run && m_en != 0 && tk != 0 && m_pos == low - 1) ? 1 : 0;
            if (m_en == 0) begin
                m_pc = 0; m_pos = 0;
            end else begin
                m_pc  = (m_pc == a_div) ? 0 : m_pc + 1;
                if (tk != 0) m_pos = (wr != 0) ? 0 : m_pos + 1;
            end
            if (m_en == 0 || wr != 0) begin
                a_div = n_div; a_step = n_step; a_comp = n_comp;
            end
            p_div = n_div; p_step = n_step; p_comp = n_comp;
            m_en = run ? 1 : 0;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            int e_tick, e_scl;
            e_tick = (m_en != 0 && m_pc == a_div) ? 1 : 0;
            e_scl  = (m_en != 0 && m_pos < (m_per() + 1) / 2) ? 0 : 1;
            chk("R2 ick_en", int'(ick_en), e_tick);
            chk("R4 scl_o", int'(scl_o), e_scl);
            chk("R8 low_stb", int'(low_stb), m_lo);
            chk("R8 high_stb", int'(high_stb), m_hi);
        end
    end

    // ---------------- directed stimulus helpers ----------------
    task automatic write_cfg(int div, int step, int comp);
        @(negedge clk);
        cfg_word = 9'((step << 3) | div);   // R1: div in [2:0], step in [8:3]
        comp_cnt = 6'(comp);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Counts enables of the low phase and the whole period, starting at a low_stb.
    task automatic measure(output int lo, output int per);
        while (!low_stb) @(negedge clk);
        lo = 0; per = 0;
        do begin
            if (ick_en) per++;
            @(negedge clk);
            if (high_stb) lo = per;
        end while (!low_stb);
    endtask

    task automatic tick_gap(output int g);
        while (!ick_en) @(negedge clk);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!ick_en);
    endtask

    int lo, per, g, seen;

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 scl_o", int'(scl_o), 1);
        chk("R9 ick_en", int'(ick_en), 0);
        chk("R9 strobes", int'(low_stb) + int'(high_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 default config gives a 20-enable period, prescale 1
        run = 1'b1;
        measure(lo, per);
        chk("R9 default period", per, 20);
        chk("R4 low of 20", lo, 10);
        tick_gap(g);
        chk("R2 gap div0", g, 1);

        // R7: idle holds SCL high, no enables; configure while idle
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!scl_o || ick_en || low_stb || high_stb) seen++;
        end
        chk("R7 idle activity", seen, 0);
        write_cfg(3, 2, 5);                 // P = 41, L = 21
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        chk("R7 start low_stb", int'(low_stb), 1);
        chk("R7 start scl low", int'(scl_o), 0);
        measure(lo, per);
        chk("R3 period 41", per, 41);
        chk("R4 low 21", lo, 21);
        chk("R4 high 20", per - lo, 20);
        tick_gap(g);
        chk("R2 gap div3", g, 4);

        // R5: mid-period write is deferred to the boundary
        measure(lo, per);
        fork
            measure(lo, per);
            begin
                repeat (30) @(negedge clk);
                cfg_word = 9'((1 << 3) | 1);    // step 1, div 1
                comp_cnt = 6'd3;                // P = 31, L = 16
                cfg_we = 1'b1;
                @(negedge clk);
                cfg_we = 1'b0;
            end
        join
        chk("R5 period in progress", per, 41);
        chk("R5 low in progress", lo, 21);
        measure(lo, per);
        chk("R5 next period", per, 31);
        chk("R4 low 16", lo, 16);
        tick_gap(g);
        chk("R5 new gap div1", g, 2);

        // R6: compensation change without a write has no effect
        comp_cnt = 6'd40;
        measure(lo, per);
        measure(lo, per);
        chk("R6 unchanged period", per, 31);
        write_cfg(1, 1, 40);                // P = 68, L = 34
        measure(lo, per);
        measure(lo, per);
        chk("R6 captured comp", per, 68);
        chk("R4 low 34", lo, 34);

        // R3: largest period
        write_cfg(0, 63, 63);               // P = 587, L = 294
        measure(lo, per);
        measure(lo, per);
        chk("R3 max period", per, 587);
        chk("R4 max low", lo, 294);
        chk("R4 max high", per - lo, 293);

        @(negedge clk);
        run = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 released after stop", int'(scl_o), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule